// File: doc/BRIEF.md
# Steady-State Error Correlation Detector

This block watches the error stream of a fast-converging adaptive filter and decides when that filter has settled. Each valid sample delivers the present error word together with its copy from one sample earlier. While the two words match, a run-length counter climbs. When they differ, the run ends and the counter is cleared, so the next run starts from zero.

A settled filter produces the same quantised error sample after sample, so its runs grow long. Once the running count is strictly greater than a programmable window threshold, the block raises a transfer-control flag. That flag tells the surrounding datapath to copy coefficients from the fast filter into the slow one. The flag is sticky, and only reset clears it.

The counter is `CNT_W` bits wide, chosen as the ceiling of log2 of the largest window needed. For example, a window near 1780 needs 11 bits and a window near 332 needs 9 bits. The count is also brought out so that its progress can be observed.

Top module: `ss_corr_detect`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the run count is 0 and the transfer flag is 0.
- R2: On a clock edge where `smp_vld` is 1 and `err_cur` equals `err_dly`, the run count increases by one, unless it is already saturated.
- R3: On a clock edge where `smp_vld` is 1 and `err_cur` differs from `err_dly`, the run count becomes 0.
- R4: On a clock edge where `smp_vld` is 0, the run count keeps its value, whatever the error inputs carry.
- R5: The run count saturates at 2^CNT_W−1 and never wraps to 0 while equal samples continue.
- R6: The transfer flag becomes 1 on the clock edge after the run count is strictly greater than `win_thr`, with both compared as unsigned numbers. A count equal to or below the threshold never sets the flag.
- R7: Once set, the transfer flag stays at 1 until reset. This holds even if the count is cleared or the threshold is raised.
- R8: With `win_thr` at 2^CNT_W−1, the transfer flag never sets, no matter how long a run lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | A new error pair is present this cycle |
| err_cur | input | ERR_W | Present error word |
| err_dly | input | ERR_W | Error word from one sample earlier |
| win_thr | input | CNT_W | Window threshold, unsigned |
| xfer_ctrl | output | 1 | Sticky coefficient-transfer request |
| run_cnt | output | CNT_W | Current run length |

## Verification
The bench sweeps every threshold value of a 4-bit counter. For each value it drives long equal runs, so the strict greater-than boundary is hit exactly. A design that compared with greater-or-equal would set the flag one sample too early. At the all-ones threshold, a counter that wrapped instead of saturating would either never reach the value that sets the flag or restart at zero, and a faulty comparison would set the flag where it must stay clear. Runs broken just short of the threshold, invalid cycles carrying mismatched errors, and a threshold raised after the flag is set catch three further faults: a counter that is not cleared between runs, a counter that advances without the strobe, and a flag that is not held.

// File: rtl/det_pkg.sv
package det_pkg;
    typedef enum logic [1:0] {
        RUN_HOLD = 2'd0,
        RUN_ADV  = 2'd1,
        RUN_CLR  = 2'd2
    } run_act_e;
endpackage

// File: rtl/det_eq.sv
module det_eq #(
    parameter int ERR_W = 8
) (
    input  logic [ERR_W-1:0] a_i,
    input  logic [ERR_W-1:0] b_i,
    output logic             same_o
);
    logic [ERR_W-1:0] bit_same;

    for (genvar g = 0; g < ERR_W; g++) begin : g_bit
        assign bit_same[g] = ~(a_i[g] ^ b_i[g]);
    end

    assign same_o = &bit_same;
endmodule

// File: rtl/det_runcnt.sv
module det_runcnt
    import det_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  run_act_e         act_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (act_i)
            RUN_ADV: if (st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
            RUN_CLR: st_d.cnt = '0;
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i == RUN_ADV && cnt_o != CNT_MAX) |=> cnt_o == $past(cnt_o) + 1'b1); // R2
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i == RUN_CLR) |=> cnt_o == '0); // R3
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i == RUN_HOLD) |=> $stable(cnt_o)); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i == RUN_ADV && cnt_o == CNT_MAX) |=> cnt_o == CNT_MAX); // R5
endmodule

// File: rtl/det_xfer_cmp.sv
module det_xfer_cmp #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic             flag_o
);
    typedef struct packed {
        logic flag;
    } cmp_st_t;

    cmp_st_t st_d, st_q;
    logic    over;

    always_comb begin
        over    = cnt_i > thr_i;
        st_d    = st_q;
        if (over) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    AST_SET_ON_OVER: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i > thr_i) |=> flag_o); // R6
    AST_NO_EARLY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(cnt_i > thr_i)); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flag_o |=> flag_o); // R7
    AST_MAX_THR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_i == {CNT_W{1'b1}} && !flag_o) |=> !flag_o); // R8
endmodule

// File: rtl/ss_corr_detect.sv
module ss_corr_detect
    import det_pkg::*;
#(
    parameter int ERR_W = 8,
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_vld,
    input  logic [ERR_W-1:0] err_cur,
    input  logic [ERR_W-1:0] err_dly,
    input  logic [CNT_W-1:0] win_thr,
    output logic             xfer_ctrl,
    output logic [CNT_W-1:0] run_cnt
);
    logic     err_same;
    run_act_e act;

    det_eq #(.ERR_W(ERR_W)) u_eq (
        .a_i    (err_cur),
        .b_i    (err_dly),
        .same_o (err_same)
    );

    always_comb begin
        if (!smp_vld)      act = RUN_HOLD;
        else if (err_same) act = RUN_ADV;
        else               act = RUN_CLR;
    end

    det_runcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .act_i (act),
        .cnt_o (run_cnt)
    );

    det_xfer_cmp #(.CNT_W(CNT_W)) u_cmp (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_i  (run_cnt),
        .thr_i  (win_thr),
        .flag_o (xfer_ctrl)
    );

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $rose(rst_n) |-> (run_cnt == '0 && !xfer_ctrl)); // R1
endmodule

// File: tb/ss_corr_detect_bench.sv
`timescale 1ns/1ps
module ss_corr_detect_bench;
    localparam int EW = 4;
    localparam int CW = 4;
    localparam int MAXC = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_vld = 1'b0;
    logic [EW-1:0] err_cur = '0;
    logic [EW-1:0] err_dly = '0;
    logic [CW-1:0] win_thr = '0;
    logic          xfer_ctrl;
    logic [CW-1:0] run_cnt;

    int checks = 0;
    int failures = 0;
    int m_cnt = 0;
    bit m_flag = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ss_corr_detect #(.ERR_W(EW), .CNT_W(CW)) u_ss_corr_detect (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .err_cur(err_cur),
        .err_dly(err_dly), .win_thr(win_thr), .xfer_ctrl(xfer_ctrl), .run_cnt(run_cnt)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; smp_vld = 1'b0;
        @(negedge clk);
        chk("R1 count in reset", int'(run_cnt), 0);
        chk("R1 flag in reset", int'(xfer_ctrl), 0);
        rst_n = 1'b1;
        m_cnt = 0; m_flag = 1'b0;
        @(posedge clk); #1;
        chk("R1 count after release", int'(run_cnt), 0);
        chk("R1 flag after release", int'(xfer_ctrl), 0);
    endtask

    task automatic step(input bit v, input int a, input int b);
        string ctag, ftag;
        int n_cnt;
        bit n_flag;
        @(negedge clk);
        smp_vld = v; err_cur = EW'(a); err_dly = EW'(b);
        if (!v) begin n_cnt = m_cnt; ctag = "R4 hold"; end
        else if (a != b) begin n_cnt = 0; ctag = "R3 clear"; end
        else if (m_cnt == MAXC) begin n_cnt = MAXC; ctag = "R5 saturate"; end
        else begin n_cnt = m_cnt + 1; ctag = "R2 advance"; end
        n_flag = m_flag | (m_cnt > int'(win_thr));
        if (m_flag) ftag = "R7 sticky";
        else if (int'(win_thr) == MAXC) ftag = "R8 max thr";
        else ftag = "R6 compare";
        @(posedge clk); #1;
        m_cnt = n_cnt; m_flag = n_flag;
        chk(ctag, int'(run_cnt), m_cnt);
        chk(ftag, int'(xfer_ctrl), int'(m_flag));
    endtask

    initial begin
        do_reset();
        // Full threshold sweep with long equal runs, breaks and idle cycles
        for (int t = 0; t <= MAXC; t++) begin
            do_reset();
            win_thr = CW'(t);
            for (int i = 0; i < MAXC + 4; i++) step(1'b1, i % 16, i % 16);
            step(1'b1, 3, 5);
            for (int i = 0; i < 3; i++) step(1'b0, i, i + 1);
            step(1'b1, 7, 7);
            step(1'b0, 1, 2);
        end
        // Runs broken just short of the threshold: flag must stay clear
        do_reset();
        win_thr = CW'(5);
        for (int r = 0; r < 6; r++) begin
            for (int i = 0; i < 5; i++) step(1'b1, 9, 9);
            step(1'b0, 9, 2);
            step(1'b1, 9, 2);
        end
        // Run up to exactly the threshold, then over it
        for (int i = 0; i < 7; i++) step(1'b1, 4, 4);
        // Raise the threshold after the flag is set
        win_thr = CW'(MAXC);
        step(1'b1, 1, 0);
        for (int i = 0; i < 4; i++) step(1'b1, 2, 2);
        // Idle with mismatched errors mid-run
        for (int i = 0; i < 5; i++) step(1'b0, i, 15 - i);
        step(1'b1, 6, 6);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule